// File: doc/BRIEF.md
# Per-Core Interrupt Controller Register Bank

This block holds the software-visible registers of a per-core interrupt controller. Software reaches it through a byte-addressed read/write port with 32-bit data. A request is taken in any cycle with `req_valid` high and answered one cycle later on `rsp_valid`, `rsp_err` and `rsp_rdata`. Each named register applies its own rules on write: some keep only part of the word, one has ones forced into its low bits, some are read-only, and some hold read-only bits inside a writable word.

The timer counter and the priority logic sit outside the block. They connect through plain data ports and one-cycle strobes. The block passes out the task priority, the divide setting and the initial count with its load strobe, the software enable and an end-of-interrupt strobe. It takes in the live current count and a vector of hardware error reports.

The error status register is cleared in two steps. A small state machine has two states, `ERR_IDLE` and `ERR_ARMED`, and these transitions:
- ARM: from `ERR_IDLE`, a write moves it to `ERR_ARMED` and leaves the register unchanged.
- CLEAR: from `ERR_ARMED`, a write moves it to `ERR_IDLE` and zeroes the register.
- DISARM: from either state, a read moves it to `ERR_IDLE`.
- HOLD: in any other cycle the state stays as it is.

Top module: `intc_regbank`

## Requirements
- R1: Every request with `req_valid` high is answered in the next cycle with `rsp_valid`=1. Read data comes back right-justified in `rsp_rdata`. The size code selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. The starting byte lane is `req_addr[1:0]`, so write data is taken from the low bytes of `req_wdata` and placed at that lane.
- R2: These 16-byte word offsets are decoded, with `req_addr[3:2]` equal to 0:
  - 0x020 identity
  - 0x030 version
  - 0x080 task priority
  - 0x0B0 end-of-interrupt
  - 0x0D0 logical destination
  - 0x0E0 destination format
  - 0x0F0 spurious vector
  - 0x280 error status
  - 0x320, 0x330, 0x340, 0x350, 0x360 and 0x370: the six local vector entries
  - 0x380 initial count
  - 0x390 current count
  - 0x3E0 divide setting

  Any other offset is reserved. A reserved access gives `rsp_err`=1, `rsp_rdata`=0 and changes no state.
- R3: An access is rejected when its size code is 3, or when the lane plus the byte count exceeds 4 (it would span two registers). A rejected access gives `rsp_err`=1 and `rsp_rdata`=0 and writes nothing.
- R4: The identity and task priority registers keep only bits 7:0 of a write. The logical destination register keeps only bits 31:24. All other bits of these registers read as 0. `task_prio` shows the stored task priority.
- R5: The destination format register resets to 0xFFFFFFFF. Each write stores the data with bits 27:0 forced to one.
- R6: The version register reads as the parameter `VERSION` (0x00050014 by default). The current count register reads the `cur_count` input. Writes to either are ignored and do not raise `rsp_err`.
- R7: All six local vector entries reset to 0x00010000. In every entry, bits 12 and 14 are read-only and keep their value across writes. Writing one entry leaves the others unchanged.
- R8: `sw_enable` equals bit 8 of the spurious vector register. The register resets to 0x000000FF, so `sw_enable` is 0 after reset. Bit 9 is stored and reads back, but it has no effect on `sw_enable`.
- R9: The error status register follows the two-step protocol: a write in `ERR_IDLE` only arms; a write in `ERR_ARMED` zeroes the register; a read of the register disarms.
- R10: Each cycle, bits set on `err_report` are ORed into the error status register. A report in the same cycle as a clearing write survives the clear.
- R11: A write to the end-of-interrupt offset stores nothing. It raises `eoi_pulse` for exactly the one cycle after the request. A read of that offset returns 0 with no error.
- R12: A write to the initial count register stores the full word and drives it on `init_count`. It pulses `init_load` for the one cycle after the request. The divide setting keeps only bits 3, 1 and 0, and drives them on `div_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_size | input | 2 | Size code (0: 1 B, 1: 2 B, 2: 4 B, 3: illegal) |
| req_wdata | input | 32 | Write data, right-justified |
| cur_count | input | 32 | Live count from the timer |
| err_report | input | 8 | Hardware error bits to record |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Reserved or rejected access |
| rsp_rdata | output | 32 | Read data, right-justified |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| sw_enable | output | 1 | Software enable |
| task_prio | output | 8 | Task priority |
| div_cfg | output | 4 | Divide setting (bit 2 always 0) |
| init_count | output | 32 | Stored initial count |
| init_load | output | 1 | Initial count written strobe |

## Verification
Two functions of the block can act on the error status register in the same cycle: the software clearing write and a new hardware error report. The bench first reports one error bit and arms the register with a write. It then issues the clearing write while `err_report` carries a different bit in that same cycle. Reading back the register must show only the new bit: the clear removed the old value, and the fresh report was not lost.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_IDENT,
        REG_VERSION,
        REG_TASKPRI,
        REG_EOI,
        REG_LOGDEST,
        REG_DESTFMT,
        REG_SPUR,
        REG_ERRSTAT,
        REG_LVEC,
        REG_INITCNT,
        REG_CURCNT,
        REG_DIVCFG
    } reg_sel_e;

    typedef enum logic {
        ERR_IDLE,
        ERR_ARMED
    } err_state_e;

    localparam logic [31:0] LVEC_RO_MASK   = 32'h0000_5000;
    localparam logic [31:0] LVEC_RESET     = 32'h0001_0000;
    localparam logic [31:0] SPUR_RESET     = 32'h0000_00FF;
    localparam logic [3:0]  DIVCFG_KEEP    = 4'b1011;
    localparam logic [31:0] DESTFMT_FORCE  = 32'h0FFF_FFFF;

endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
    import intc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_LVT = 6
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [1:0]                size,
    output reg_sel_e                  sel,
    output logic [$clog2(NUM_LVT)-1:0] lvt_idx,
    output logic                      span_err,
    output logic [3:0]                be
);
    localparam int LVT_IW   = $clog2(NUM_LVT);
    localparam int LVT_BASE = 'h320;

    logic [2:0]        nbytes;
    logic [4:0]        fill;
    logic [ADDR_W-1:0] word;

    always_comb begin
        unique case (size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            2'd2:    nbytes = 3'd4;
            default: nbytes = 3'd0;
        endcase
        fill     = (5'd1 << nbytes) - 5'd1;
        be       = fill[3:0] << addr[1:0];
        span_err = (size == 2'd3) || (({1'b0, addr[1:0]} + nbytes) > 3'd4);
    end

    always_comb begin
        word    = {addr[ADDR_W-1:4], 4'b0000};
        sel     = REG_NONE;
        lvt_idx = '0;
        if (addr[3:2] == 2'b00) begin
            if      (word == ADDR_W'('h020)) sel = REG_IDENT;
            else if (word == ADDR_W'('h030)) sel = REG_VERSION;
            else if (word == ADDR_W'('h080)) sel = REG_TASKPRI;
            else if (word == ADDR_W'('h0B0)) sel = REG_EOI;
            else if (word == ADDR_W'('h0D0)) sel = REG_LOGDEST;
            else if (word == ADDR_W'('h0E0)) sel = REG_DESTFMT;
            else if (word == ADDR_W'('h0F0)) sel = REG_SPUR;
            else if (word == ADDR_W'('h280)) sel = REG_ERRSTAT;
            else if (word == ADDR_W'('h380)) sel = REG_INITCNT;
            else if (word == ADDR_W'('h390)) sel = REG_CURCNT;
            else if (word == ADDR_W'('h3E0)) sel = REG_DIVCFG;
            for (int i = 0; i < NUM_LVT; i++) begin
                if (word == ADDR_W'(LVT_BASE + i * 16)) begin
                    sel     = REG_LVEC;
                    lvt_idx = LVT_IW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/intc_lane.sv
module intc_lane (
    input  logic [31:0] old_word,
    input  logic [31:0] wdata,
    input  logic [31:0] rd_word,
    input  logic [3:0]  be,
    input  logic [1:0]  lane,
    output logic [31:0] merged,
    output logic [31:0] rd_data
);
    logic [31:0] wshift;
    logic [31:0] rshift;
    logic [3:0]  rmask;

    assign wshift = wdata << {lane, 3'b000};
    assign rshift = rd_word >> {lane, 3'b000};
    assign rmask  = be >> lane;

    for (genvar b = 0; b < 4; b++) begin : g_byte
        assign merged[8*b +: 8]  = be[b]    ? wshift[8*b +: 8] : old_word[8*b +: 8];
        assign rd_data[8*b +: 8] = rmask[b] ? rshift[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/intc_err_fsm.sv
module intc_err_fsm
    import intc_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [ERR_W-1:0] report,
    output logic [ERR_W-1:0] status
);
    err_state_e      state_q, state_d;
    logic            clear;
    logic [ERR_W-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ERR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        clear   = 1'b0;
        unique case (state_q)
            ERR_IDLE: begin
                if (wr) state_d = ERR_ARMED;
            end
            ERR_ARMED: begin
                if (wr) begin
                    state_d = ERR_IDLE;
                    clear   = 1'b1;
                end else if (rd) begin
                    state_d = ERR_IDLE;
                end
            end
            default: state_d = ERR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (clear ? '0 : status_q) | report;
    end

    assign status = status_q;

    AST_ERR_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ERR_IDLE && wr) |=> (state_q == ERR_ARMED && status == ($past(status) | $past(report)))); // R9
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ERR_ARMED && wr) |=> (state_q == ERR_IDLE && status == $past(report))); // R10
    AST_ERR_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> (state_q == ERR_IDLE)); // R9

endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
    import intc_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          NUM_LVT = 6,
    parameter int          ERR_W   = 8,
    parameter logic [31:0] VERSION = 32'h0005_0014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       cur_count,
    input  logic [ERR_W-1:0]  err_report,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              eoi_pulse,
    output logic              sw_enable,
    output logic [7:0]        task_prio,
    output logic [3:0]        div_cfg,
    output logic [31:0]       init_count,
    output logic              init_load
);
    localparam int LVT_IW = $clog2(NUM_LVT);

    reg_sel_e          sel;
    logic [LVT_IW-1:0] lvt_idx;
    logic              span_err;
    logic [3:0]        be;
    logic              acc_ok, wr_ok, rd_ok;
    logic [31:0]       cur_word, merged, rd_data;
    logic [ERR_W-1:0]  err_status;

    logic [7:0]  ident_q, tpr_q, ldest_q;
    logic [3:0]  dfmt_q, dcfg_q;
    logic [31:0] spur_q, icnt_q;
    logic [31:0] lvt_q [NUM_LVT];
    logic        rsp_valid_q, rsp_err_q, eoi_q, load_q;
    logic [31:0] rsp_rdata_q;

    intc_addr_dec #(.ADDR_W(ADDR_W), .NUM_LVT(NUM_LVT)) u_dec (
        .addr     (req_addr),
        .size     (req_size),
        .sel      (sel),
        .lvt_idx  (lvt_idx),
        .span_err (span_err),
        .be       (be)
    );

    assign acc_ok = req_valid && (sel != REG_NONE) && !span_err;
    assign wr_ok  = acc_ok && req_write;
    assign rd_ok  = acc_ok && !req_write;

    always_comb begin
        unique case (sel)
            REG_IDENT:   cur_word = {24'h0, ident_q};
            REG_VERSION: cur_word = VERSION;
            REG_TASKPRI: cur_word = {24'h0, tpr_q};
            REG_LOGDEST: cur_word = {ldest_q, 24'h0};
            REG_DESTFMT: cur_word = {dfmt_q, 28'hFFF_FFFF};
            REG_SPUR:    cur_word = spur_q;
            REG_ERRSTAT: cur_word = 32'(err_status);
            REG_LVEC:    cur_word = lvt_q[lvt_idx];
            REG_INITCNT: cur_word = icnt_q;
            REG_CURCNT:  cur_word = cur_count;
            REG_DIVCFG:  cur_word = {28'h0, dcfg_q};
            default:     cur_word = 32'h0;
        endcase
    end

    intc_lane u_lane (
        .old_word (cur_word),
        .wdata    (req_wdata),
        .rd_word  (cur_word),
        .be       (be),
        .lane     (req_addr[1:0]),
        .merged   (merged),
        .rd_data  (rd_data)
    );

    intc_err_fsm #(.ERR_W(ERR_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ok && sel == REG_ERRSTAT),
        .rd     (rd_ok && sel == REG_ERRSTAT),
        .report (err_report),
        .status (err_status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ident_q <= '0;
            tpr_q   <= '0;
            ldest_q <= '0;
            dfmt_q  <= 4'hF;
            spur_q  <= SPUR_RESET;
            icnt_q  <= '0;
            dcfg_q  <= '0;
        end else if (wr_ok) begin
            unique case (sel)
                REG_IDENT:   ident_q <= merged[7:0];
                REG_TASKPRI: tpr_q   <= merged[7:0];
                REG_LOGDEST: ldest_q <= merged[31:24];
                REG_DESTFMT: dfmt_q  <= merged[31:28];
                REG_SPUR:    spur_q  <= merged;
                REG_INITCNT: icnt_q  <= merged;
                REG_DIVCFG:  dcfg_q  <= merged[3:0] & DIVCFG_KEEP;
                default:     ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_LVT; i++) begin : g_lvt
        logic hit_i;
        assign hit_i = wr_ok && (sel == REG_LVEC) && (lvt_idx == LVT_IW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     lvt_q[i] <= LVEC_RESET;
            else if (hit_i) lvt_q[i] <= (merged & ~LVEC_RO_MASK) | (lvt_q[i] & LVEC_RO_MASK);
        end

        AST_LVT_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i |=> (lvt_q[i][12] == $past(lvt_q[i][12]) && lvt_q[i][14] == $past(lvt_q[i][14]))); // R7
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
            eoi_q       <= 1'b0;
            load_q      <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_err_q   <= req_valid && !acc_ok;
            rsp_rdata_q <= rd_ok ? rd_data : 32'h0;
            eoi_q       <= wr_ok && (sel == REG_EOI);
            load_q      <= wr_ok && (sel == REG_INITCNT);
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_err    = rsp_err_q;
    assign rsp_rdata  = rsp_rdata_q;
    assign eoi_pulse  = eoi_q;
    assign init_load  = load_q;
    assign sw_enable  = spur_q[8];
    assign task_prio  = tpr_q;
    assign div_cfg    = dcfg_q;
    assign init_count = icnt_q;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && span_err && err_report == '0) |=>
            ($stable(tpr_q) && $stable(icnt_q) && $stable(spur_q) && !rsp_valid_q == 1'b0 && rsp_err)); // R3
    AST_RESERVED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel == REG_NONE) |=> (rsp_err && rsp_rdata == 32'h0)); // R2
    AST_EOI_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel == REG_EOI && !span_err) |=> eoi_pulse); // R11
    AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel == REG_VERSION && req_size == 2'd2 && req_addr[1:0] == 2'd0)
            |=> (rsp_rdata == VERSION)); // R6
    AST_SWEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel == REG_SPUR && req_size == 2'd2 && req_addr[1:0] == 2'd0)
            |=> (sw_enable == $past(req_wdata[8]))); // R8

endmodule

// File: tb/test_intc_regbank.sv
module test_intc_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] cur_count = 32'hCAFE_0001;
    logic [7:0]  err_report = '0;
    logic        rsp_valid, rsp_err, eoi_pulse, sw_enable, init_load;
    logic [31:0] rsp_rdata, init_count;
    logic [7:0]  task_prio;
    logic [3:0]  div_cfg;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] s_data;
    logic        s_err, s_valid, s_eoi, s_load;

    always #5 clk = ~clk;

    intc_regbank i_intc_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .cur_count(cur_count), .err_report(err_report), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .eoi_pulse(eoi_pulse),
        .sw_enable(sw_enable), .task_prio(task_prio), .div_cfg(div_cfg),
        .init_count(init_count), .init_load(init_load)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        exp_err;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h0E0, 2'd2, 32'h0,        32'hFFFF_FFFF, 1'b0}, // R5 reset
        '{1'b0, 12'h330, 2'd2, 32'h0,        32'h0001_0000, 1'b0}, // R7 reset
        '{1'b1, 12'h020, 2'd2, 32'hAABB_CCDD, 32'h0,        1'b0}, // R4
        '{1'b0, 12'h020, 2'd2, 32'h0,        32'h0000_00DD, 1'b0}, // R4
        '{1'b1, 12'h080, 2'd2, 32'h1234_5678, 32'h0,        1'b0}, // R4
        '{1'b0, 12'h080, 2'd2, 32'h0,        32'h0000_0078, 1'b0}, // R4
        '{1'b1, 12'h0D0, 2'd2, 32'h1234_5678, 32'h0,        1'b0}, // R4
        '{1'b0, 12'h0D0, 2'd2, 32'h0,        32'h1200_0000, 1'b0}, // R4
        '{1'b1, 12'h0E0, 2'd2, 32'h3000_0000, 32'h0,        1'b0}, // R5
        '{1'b0, 12'h0E0, 2'd2, 32'h0,        32'h3FFF_FFFF, 1'b0}, // R5
        '{1'b1, 12'h030, 2'd2, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R6
        '{1'b0, 12'h030, 2'd2, 32'h0,        32'h0005_0014, 1'b0}, // R6
        '{1'b1, 12'h320, 2'd2, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R7
        '{1'b0, 12'h320, 2'd2, 32'h0,        32'hFFFF_AFFF, 1'b0}, // R7
        '{1'b0, 12'h340, 2'd2, 32'h0,        32'h0001_0000, 1'b0}, // R7
        '{1'b1, 12'h3E0, 2'd2, 32'hFFFF_FFFF, 32'h0,        1'b0}, // R12
        '{1'b0, 12'h3E0, 2'd2, 32'h0,        32'h0000_000B, 1'b0}, // R12
        '{1'b1, 12'h021, 2'd0, 32'h0000_00EE, 32'h0,        1'b0}, // R4 lane1
        '{1'b0, 12'h020, 2'd2, 32'h0,        32'h0000_00DD, 1'b0}, // R4
        '{1'b1, 12'h020, 2'd0, 32'h0000_0011, 32'h0,        1'b0}, // R1
        '{1'b0, 12'h020, 2'd0, 32'h0,        32'h0000_0011, 1'b0}, // R1
        '{1'b0, 12'h0D3, 2'd0, 32'h0,        32'h0000_0012, 1'b0}, // R1
        '{1'b0, 12'h0D2, 2'd1, 32'h0,        32'h0000_1200, 1'b0}, // R1
        '{1'b0, 12'h0D3, 2'd1, 32'h0,        32'h0,         1'b1}, // R3
        '{1'b1, 12'h082, 2'd2, 32'hFFFF_FFFF, 32'h0,        1'b1}, // R3
        '{1'b0, 12'h080, 2'd2, 32'h0,        32'h0000_0078, 1'b0}, // R3
        '{1'b0, 12'h020, 2'd3, 32'h0,        32'h0,         1'b1}, // R3
        '{1'b0, 12'h044, 2'd2, 32'h0,        32'h0,         1'b1}, // R2
        '{1'b0, 12'h024, 2'd2, 32'h0,        32'h0,         1'b1}, // R2
        '{1'b1, 12'h400, 2'd2, 32'h1,        32'h0,         1'b1}, // R2
        '{1'b1, 12'h390, 2'd2, 32'h0,        32'h0,         1'b0}, // R6
        '{1'b0, 12'h390, 2'd2, 32'h0,        32'hCAFE_0001, 1'b0}, // R6
        '{1'b0, 12'h380, 2'd2, 32'h0,        32'h0,         1'b0}, // R12
        '{1'b0, 12'h0B0, 2'd2, 32'h0,        32'h0,         1'b0}, // R11
        '{1'b0, 12'h3E2, 2'd1, 32'h0,        32'h0,         1'b0}, // R1
        '{1'b0, 12'h3E0, 2'd0, 32'h0,        32'h0000_000B, 1'b0}  // R1
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input logic [7:0] rep);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = w;
        req_addr   = a;
        req_size   = sz;
        req_wdata  = d;
        err_report = rep;
        @(posedge clk);
        #1;
        s_data  = rsp_rdata;
        s_err   = rsp_err;
        s_valid = rsp_valid;
        s_eoi   = eoi_pulse;
        s_load  = init_load;
        @(negedge clk);
        req_valid  = 1'b0;
        err_report = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state of outputs (R1, R8, R11, R12, R4)
        check("R1 rsp_valid idle", 32'(rsp_valid), 32'h0);
        check("R8 sw_enable reset", 32'(sw_enable), 32'h0);
        check("R11 eoi_pulse reset", 32'(eoi_pulse), 32'h0);
        check("R12 init_count reset", init_count, 32'h0);
        check("R4 task_prio reset", 32'(task_prio), 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, 8'h00);
            check($sformatf("vector %0d rdata", i), s_data, VECS[i].exp);
            check($sformatf("vector %0d err", i), 32'(s_err), 32'(VECS[i].exp_err));
            check($sformatf("vector %0d R1 valid", i), 32'(s_valid), 32'h1);
        end
        check("R4 task_prio port", 32'(task_prio), 32'h78);
        check("R12 div_cfg port", 32'(div_cfg), 32'hB);

        // R11 end-of-interrupt strobe
        access(1'b1, 12'h0B0, 2'd2, 32'hFFFF_FFFF, 8'h00);
        check("R11 eoi high", 32'(s_eoi), 32'h1);
        check("R11 eoi no err", 32'(s_err), 32'h0);
        @(posedge clk); #1;
        check("R11 eoi one cycle", 32'(eoi_pulse), 32'h0);
        access(1'b0, 12'h0B0, 2'd2, 32'h0, 8'h00);
        check("R11 eoi read zero", s_data, 32'h0);

        // R8 spurious vector enable
        access(1'b1, 12'h0F0, 2'd2, 32'h0000_0100, 8'h00);
        check("R8 enable set", 32'(sw_enable), 32'h1);
        access(1'b1, 12'h0F0, 2'd2, 32'h0000_0200, 8'h00);
        check("R8 bit9 no effect", 32'(sw_enable), 32'h0);
        access(1'b0, 12'h0F0, 2'd2, 32'h0, 8'h00);
        check("R8 readback", s_data, 32'h0000_0200);

        // R12 initial count
        access(1'b1, 12'h380, 2'd2, 32'h0000_1234, 8'h00);
        check("R12 load strobe", 32'(s_load), 32'h1);
        check("R12 init_count", init_count, 32'h0000_1234);
        @(posedge clk); #1;
        check("R12 load one cycle", 32'(init_load), 32'h0);
        access(1'b0, 12'h380, 2'd2, 32'h0, 8'h00);
        check("R12 readback", s_data, 32'h0000_1234);

        // R9 error status protocol
        access(1'b0, 12'h020, 2'd2, 32'h0, 8'h04);
        access(1'b1, 12'h280, 2'd2, 32'h0, 8'h00);
        check("R9 arm no error", 32'(s_err), 32'h0);
        access(1'b0, 12'h280, 2'd2, 32'h0, 8'h00);
        check("R9 arm keeps value", s_data, 32'h04);
        access(1'b1, 12'h280, 2'd2, 32'h0, 8'h00);
        access(1'b0, 12'h280, 2'd2, 32'h0, 8'h00);
        check("R9 read disarmed", s_data, 32'h04);
        access(1'b1, 12'h280, 2'd2, 32'h0, 8'h00);
        access(1'b1, 12'h280, 2'd2, 32'h0, 8'h00);
        access(1'b0, 12'h280, 2'd2, 32'h0, 8'h00);
        check("R9 second write clears", s_data, 32'h0);

        // R10 report in the same cycle as the clearing write
        access(1'b0, 12'h020, 2'd2, 32'h0, 8'h10);
        access(1'b1, 12'h280, 2'd2, 32'h0, 8'h00);
        access(1'b1, 12'h280, 2'd2, 32'h0, 8'h20);
        access(1'b0, 12'h280, 2'd2, 32'h0, 8'h00);
        check("R10 report survives clear", s_data, 32'h20);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule